// File: doc/BRIEF.md
# Segment Byte-Packing FIFO Writer

This block sits between a DMA read engine and a 32-bit-wide transmit FIFO. The engine hands over data one segment at a time. A segment is announced by its byte length and then delivered as a series of 32-bit words read from memory. Each segment starts on a 4-byte boundary, but its length can be any value from 1 to 65536 bytes. The block packs the valid bytes of all segments back to back into dense FIFO entries. When a segment ends partway through an entry, the next segment's bytes go into the lanes that are still free. The packer never advances to a new entry until all four lanes of the current one are filled.

Up to three leftover bytes stay in a carry register, together with a count of how many lanes are filled. When the whole transfer is done, a flush request writes out a partly filled entry. The unused lanes are set to zero, and a lane mask tells the FIFO which lanes hold real bytes. The FIFO's full flag holds off the data input, so no word is taken in unless its result can be written.

Top module: `seg_byte_packer`

## Requirements
- R1: After reset, `wr_en` is 0, `cmd_ready` is 1, `din_ready` is 0, and no bytes are held.
- R2: Lane i of a word carries bits [8i+7:8i], and lane 0 is the lowest address. The bytes written to the FIFO, read entry by entry from lane 0 upward, are exactly the bytes of the segments in the order they arrived. Each segment's first byte comes from lane 0 of its first data word.
- R3: In a segment's last data word, the lanes at or beyond the segment length are discarded and never reach the FIFO.
- R4: An entry is written only once it holds four valid bytes, or on flush. Bytes left over from one segment keep their lanes, and the next segment continues at the next free lane. Example: segments of 4, 3 and 4 bytes with words 0x01234567, 0xABCDDEAD and 0x89122345 give entries 0x01234567, then 0x45CDDEAD, with 0x891223 left pending.
- R5: `cmd_ready` is 1 only while no segment is in progress. A segment of L bytes takes exactly ceil(L/4) data words, after which `cmd_ready` returns to 1.
- R6: `din_ready` is 0 while no segment is in progress or while `wr_full` is 1. A word accepted at a clock edge produces its FIFO write (if any) in the cycle right after that edge. No write happens in a cycle whose preceding edge saw `wr_full` high.
- R7: A flush is taken when `flush` and `flush_ready` are both high. `flush_ready` is high when no segment is in progress and `wr_full` is 0. If n lanes are pending (n = 1 to 3), the flush writes them in lanes 0 to n-1, sets the other lanes to zero, and gives a mask with the low n bits set. With nothing pending, a flush writes nothing. Any entry written without a flush has mask 4'hF.
- R8: `cmd_len` is 17 bits wide and takes lengths from 1 to 65536. A 65536-byte segment is packed like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Segment command offered |
| cmd_ready | output | 1 | No segment in progress; command accepted |
| cmd_len | input | 17 | Segment length in bytes (1 to 65536) |
| din_valid | input | 1 | Data word offered |
| din_ready | output | 1 | Data word accepted this edge |
| din_data | input | 32 | Data word read from memory, little-endian lanes |
| flush | input | 1 | End-of-transfer request to write out pending bytes |
| flush_ready | output | 1 | Flush can be taken this edge |
| wr_en | output | 1 | FIFO write strobe (registered) |
| wr_data | output | 32 | FIFO entry data (registered) |
| wr_mask | output | 4 | Valid lane mask of the written entry |
| wr_full | input | 1 | FIFO cannot take a write in the next cycle |

## Verification
The assertions assume that `cmd_len` is never zero when a command is accepted. They also assume that `wr_full` is a registered flag that is valid at every edge after reset. The bench only issues lengths from 1 upward and drives `wr_full` just after each rising edge. Every check of the packed stream relies on flushes being issued only between segments. For that reason the bench sends a flush only after the last data word of a segment has been accepted.

// File: rtl/seg_pack_pkg.sv
package seg_pack_pkg;

  // Action applied to the lane merger in one cycle
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_PUSH  = 2'd1,
    ACT_FLUSH = 2'd2
  } merge_act_e;

  // Mask with the low n bits set (n at most 8)
  function automatic logic [7:0] low_ones(input int n);
    logic [8:0] t;
    t = (9'd1 << n) - 9'd1;
    return t[7:0];
  endfunction

endpackage

// File: rtl/seg_len_tracker.sv
module seg_len_tracker #(
  parameter int LEN_W = 17,
  parameter int BYTES = 4,
  parameter int NB_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_take,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             word_take,
  output logic             active,
  output logic [NB_W-1:0]  word_bytes
);

  logic [LEN_W-1:0] remain;

  assign active     = (remain != '0);
  assign word_bytes = (remain >= LEN_W'(BYTES)) ? NB_W'(BYTES) : remain[NB_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (cmd_take)
      remain <= cmd_len;
    else if (word_take)
      remain <= remain - LEN_W'(word_bytes);
  end

  // R8
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_take |-> (cmd_len != '0));

  // R5
  seg_done_chk: assert property (@(posedge clk) disable iff (rst)
    (word_take && remain <= LEN_W'(BYTES)) |=> !active);

endmodule

// File: rtl/lane_merger.sv
module lane_merger
  import seg_pack_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int FILL_W = 2,
  parameter int NB_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  merge_act_e         act,
  input  logic [BYTES*8-1:0] din,
  input  logic [NB_W-1:0]    nb,
  output logic               emit,
  output logic [BYTES*8-1:0] word,
  output logic [BYTES-1:0]   mask
);

  localparam int DW  = BYTES * 8;
  localparam int CW  = (BYTES - 1) * 8;
  localparam int WIN = (2 * BYTES - 1) * 8;

  logic [CW-1:0]     carry;
  logic [FILL_W-1:0] fill;
  logic [DW-1:0]     din_kept;
  logic [WIN-1:0]    window;
  logic [NB_W-1:0]   total;
  logic              reaches_full;

  // Drop lanes beyond the byte count of this word
  always_comb begin
    for (int i = 0; i < BYTES; i++)
      din_kept[8*i +: 8] = (NB_W'(i) < nb) ? din[8*i +: 8] : 8'h00;
  end

  assign window       = WIN'(carry) | (WIN'(din_kept) << {fill, 3'b000});
  assign total        = NB_W'(fill) + nb;
  assign reaches_full = (total >= NB_W'(BYTES));

  always_comb begin
    emit = 1'b0;
    word = '0;
    mask = '0;
    if (act == ACT_PUSH && reaches_full) begin
      emit = 1'b1;
      word = window[DW-1:0];
      mask = '1;
    end else if (act == ACT_FLUSH && fill != '0) begin
      emit = 1'b1;
      word = {{(DW-CW){1'b0}}, carry};
      mask = BYTES'(low_ones(int'(fill)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry <= '0;
      fill  <= '0;
    end else if (act == ACT_PUSH) begin
      if (reaches_full) begin
        carry <= window[DW +: CW];
        fill  <= FILL_W'(total - NB_W'(BYTES));
      end else begin
        carry <= window[CW-1:0];
        fill  <= FILL_W'(total);
      end
    end else if (act == ACT_FLUSH) begin
      carry <= '0;
      fill  <= '0;
    end
  end

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_FLUSH) |=> (fill == '0));

  // R4
  fill_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_PUSH && !emit) |=> (fill > $past(fill)));

endmodule

// File: rtl/pack_out_reg.sv
module pack_out_reg #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               emit,
  input  logic [BYTES*8-1:0] word,
  input  logic [BYTES-1:0]   mask,
  output logic               wr_en,
  output logic [BYTES*8-1:0] wr_data,
  output logic [BYTES-1:0]   wr_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_mask <= '0;
    end else begin
      wr_en   <= emit;
      wr_data <= word;
      wr_mask <= mask;
    end
  end

  // R7
  mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_mask != '0) && ((wr_mask & (wr_mask + 1'b1)) == '0)));

endmodule

// File: rtl/seg_byte_packer.sv
module seg_byte_packer
  import seg_pack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [DATA_W-1:0] din_data,
  input  logic              flush,
  output logic              flush_ready,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W/8-1:0] wr_mask,
  input  logic              wr_full
);

  localparam int BYTES  = DATA_W / 8;
  localparam int FILL_W = $clog2(BYTES);
  localparam int NB_W   = FILL_W + 1;

  logic             seg_active;
  logic [NB_W-1:0]  word_bytes;
  logic             cmd_take;
  logic             word_take;
  logic             flush_take;
  merge_act_e       act;
  logic             emit;
  logic [DATA_W-1:0] m_word;
  logic [BYTES-1:0] m_mask;

  assign cmd_ready   = !seg_active;
  assign din_ready   = seg_active && !wr_full;
  assign flush_ready = !seg_active && !wr_full;
  assign cmd_take    = cmd_valid && cmd_ready;
  assign word_take   = din_valid && din_ready;
  assign flush_take  = flush && flush_ready;

  always_comb begin
    if (word_take)       act = ACT_PUSH;
    else if (flush_take) act = ACT_FLUSH;
    else                 act = ACT_IDLE;
  end

  seg_len_tracker #(.LEN_W(LEN_W), .BYTES(BYTES), .NB_W(NB_W)) u_len (
    .clk        (clk),
    .rst        (rst),
    .cmd_take   (cmd_take),
    .cmd_len    (cmd_len),
    .word_take  (word_take),
    .active     (seg_active),
    .word_bytes (word_bytes)
  );

  lane_merger #(.BYTES(BYTES), .FILL_W(FILL_W), .NB_W(NB_W)) u_merge (
    .clk  (clk),
    .rst  (rst),
    .act  (act),
    .din  (din_data),
    .nb   (word_bytes),
    .emit (emit),
    .word (m_word),
    .mask (m_mask)
  );

  pack_out_reg #(.BYTES(BYTES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .emit    (emit),
    .word    (m_word),
    .mask    (m_mask),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mask (wr_mask)
  );

  // R6
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(wr_full));

  // R7
  partial_only_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mask != '1) |-> $past(flush_take));

endmodule

// File: tb/seg_byte_packer_tb.sv
module seg_byte_packer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [16:0] cmd_len = '0;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [31:0] din_data = '0;
  logic        flush = 1'b0;
  logic        flush_ready;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [3:0]  wr_mask;
  logic        wr_full = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int n_wr     = 0;
  bit stall_en = 0;
  bit full_prev = 0;
  bit done = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] log_data[$];
  logic [3:0]  log_mask[$];

  always #4 clk = ~clk;  // 125 MHz

  seg_byte_packer u_dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .flush(flush), .flush_ready(flush_ready),
    .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask), .wr_full(wr_full)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Random back-pressure, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    wr_full = stall_en ? ($urandom % 3 == 0) : 1'b0;
  end

  // Output monitor against the reference byte queue
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        bit ok = 1;
        logic [31:0] expw = '0;
        n_wr++;
        log_data.push_back(wr_data);
        log_mask.push_back(wr_mask);
        for (int l = 0; l < 4; l++) begin
          if (wr_mask[l]) begin
            if (exp_q.size() == 0) ok = 0;
            else begin
              expw[8*l +: 8] = exp_q.pop_front();
              if (wr_data[8*l +: 8] != expw[8*l +: 8]) ok = 0;
            end
          end else if (wr_data[8*l +: 8] != 8'h00) ok = 0;  // R7 zero padding
        end
        check(ok, "R2 packed entry", wr_data, expw);
        check(!full_prev, "R6 write after full", 1, 0);
      end
      if (wr_full) check(!din_ready, "R6 din_ready while full", din_ready, 0);
      full_prev = wr_full;
    end
  end

  task automatic send_cmd(input int len);
    cmd_valid = 1'b1;
    cmd_len   = 17'(len);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] d, input int nb);
    din_valid = 1'b1;
    din_data  = d;
    do @(negedge clk); while (!din_ready);
    @(posedge clk); #1;
    din_valid = 1'b0;
    for (int l = 0; l < nb; l++) exp_q.push_back(d[8*l +: 8]);
  endtask

  task automatic send_seg(input int len);
    int left;
    left = len;
    send_cmd(len);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R5 busy during segment", cmd_ready, 0);
    @(posedge clk); #1;
    while (left > 0) begin
      send_word($urandom, (left >= 4) ? 4 : left);  // R3 garbage in dropped lanes
      left -= (left >= 4) ? 4 : left;
    end
    @(negedge clk);
    check(cmd_ready == 1'b1, "R5 ready after last word", cmd_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    do @(negedge clk); while (!flush_ready);
    @(posedge clk); #1;
    flush = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int w0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    check(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    check(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
    check(din_ready == 1'b0, "R1 din_ready after reset", din_ready, 0);
    @(posedge clk); #1;
    w0 = n_wr;
    do_flush();
    check(n_wr == w0, "R1 nothing held after reset", n_wr - w0, 0);

    // R4 worked example, R3 drops lane 3 of the second word
    log_data.delete(); log_mask.delete();
    send_cmd(4); send_word(32'h01234567, 4);
    send_cmd(3); send_word(32'hABCDDEAD, 3);
    send_cmd(4); send_word(32'h89122345, 4);
    repeat (2) @(posedge clk); #1;
    check(log_data.size() == 2, "R4 entries before flush", log_data.size(), 2);
    if (log_data.size() == 2) begin
      check(log_data[0] == 32'h01234567, "R4 entry0", log_data[0], 32'h01234567);
      check(log_data[1] == 32'h45CDDEAD, "R4 R3 entry1", log_data[1], 32'h45CDDEAD);
    end
    do_flush();
    check(log_data.size() == 3, "R7 flush writes tail", log_data.size(), 3);
    if (log_data.size() == 3) begin
      check(log_data[2] == 32'h00891223, "R7 padded tail", log_data[2], 32'h00891223);
      check(log_mask[2] == 4'b0111, "R7 tail mask", log_mask[2], 4'b0111);
    end

    // R2 R5 R7 sweep over pairs of short segments
    for (int a = 1; a <= 8; a++) begin
      for (int b = 1; b <= 8; b++) begin
        w0 = n_wr;
        send_seg(a);
        send_seg(b);
        do_flush();
        check(n_wr - w0 == (a + b + 3) / 4, "R5 R7 write count", n_wr - w0, (a + b + 3) / 4);
        check(exp_q.size() == 0, "R2 all bytes delivered", exp_q.size(), 0);
      end
    end

    // R2 R3 R6 random lengths with back-pressure
    stall_en = 1;
    for (int s = 0; s < 200; s++) send_seg(1 + $urandom % 64);
    do_flush();
    stall_en = 0;
    repeat (3) @(posedge clk); #1;
    check(exp_q.size() == 0, "R2 random stream drained", exp_q.size(), 0);

    // R8 maximum length, whole number of entries so flush writes nothing
    w0 = n_wr;
    send_seg(65536);
    do_flush();
    check(n_wr - w0 == 16384, "R8 max segment entries", n_wr - w0, 16384);
    check(exp_q.size() == 0, "R8 max segment drained", exp_q.size(), 0);

    finish_run();
  end

endmodule